// File: doc/BRIEF.md
# Per-Processor Interrupt Delivery Unit

This unit serves one processor output of a multi-source interrupt controller. A source router sends it delivery requests. Each request carries a source index and a priority. The unit records accepted requests in a per-source "raised" set. Interrupts the processor has taken are recorded in a separate "in-service" set. The unit drives a level interrupt line to the processor and asserts it only when a newly raised request can preempt the work already in service.

The processor reaches the unit through a small register port with four registers:
- a 4-bit task-priority threshold;
- an acknowledge register that returns the vector of the best raised source, or a spurious vector;
- an end-of-interrupt register that retires the best in-service entry and re-evaluates what is still raised;
- an identity register.

Per-source priorities and vectors come in on flat table buses. Per-source sense (level or edge) comes in on its own bus. The unit tracks an activity flag for each source. For an edge source, the acknowledge pulses a pending-clear request back to the router.

Top module: `intr_cpu_deliver`

## Requirements
- R1: After reset the interrupt line is low, no source is active and the task priority is 0xF. The register selects are: 0 = task priority, 1 = acknowledge, 2 = end of interrupt, 3 = identity. A read of select 2 returns 0 and a read of select 3 returns UNIT_ID. Read data appears on the cycle after the read strobe.
- R2: A write to the task-priority register keeps only its low 4 bits.
- R3: A delivery whose priority is less than or equal to the task priority is dropped: no activity, no raised bit, no change of the interrupt line.
- R4: A delivery for a source whose raised bit is already set is dropped as missed, and the interrupt line does not change.
- R5: An accepted delivery sets the source's activity flag and raised bit. It asserts the interrupt line when its priority is at least the best raised priority and either nothing is in service or its priority is strictly above the best in-service priority.
- R6: An acknowledge read deasserts the interrupt line. With the raised set empty it returns the spurious vector 0xFF.
- R7: The best entry of a set is the member with the highest priority from the table. On equal priority the lowest source index wins.
- R8: On acknowledge, the best raised source loses its raised bit. If it is active and its table priority is strictly above the task priority, it enters the in-service set and its vector is returned. Otherwise its activity flag is cleared and 0xFF is returned.
- R9: Acknowledging an edge source (sense bit 0) clears its activity flag and pulses the pending-clear output with its index for one cycle. A level source (sense bit 1) keeps its flag and gets no pulse.
- R10: An end-of-interrupt write removes the best in-service entry. It then asserts the line if the raised set is non-empty and either nothing remains in service or the best raised priority is strictly above the new best in-service priority.
- R11: A bit set on the quiet input clears that source's activity flag.
- R12: When an acknowledge or end-of-interrupt lands in the same cycle as a delivery, the register operation is applied first and the delivery is judged against the resulting sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dlv_valid | input | 1 | Delivery request strobe |
| dlv_src | input | SRC_W | Source index of the delivery |
| dlv_prio | input | PRIO_W | Priority carried by the delivery |
| src_prio_flat | input | NUM_SRC*PRIO_W | Per-source priority table |
| src_vec_flat | input | NUM_SRC*VEC_W | Per-source vector table |
| src_level | input | NUM_SRC | Per-source sense, 1 = level |
| src_quiet | input | NUM_SRC | Clears activity flags (level input fell) |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | Register read select |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register write select |
| wr_data | input | DATA_W | Register write data |
| rd_data | output | DATA_W | Registered read data |
| irq_out | output | 1 | Level interrupt to the processor |
| ack_clr | output | 1 | Pending-clear pulse for an acknowledged edge source |
| ack_clr_src | output | SRC_W | Source index for ack_clr |
| src_active | output | NUM_SRC | Activity flag per source |

## Verification
The hardest situation to reach is an acknowledge and a delivery for the same source in one cycle. The outcome differs by operation order: handled first, the delivery would be missed, and handled second, it re-raises the source. The stimulus first raises the source, then strikes the acknowledge and a redelivery together. It then issues an end-of-interrupt and checks that the line rises again and that a second acknowledge returns the same vector. Stale acknowledges are staged the same way. A source is raised, and then either its table priority is lowered under a newly written threshold or its activity flag is cleared through the quiet input. Only after that comes the acknowledge.

// File: rtl/intr_pkg.sv
// Shared definitions for the per-processor interrupt delivery unit.
package intr_pkg;
    // Register select codes on the processor register port.
    typedef enum logic [1:0] {
        SEL_TASK = 2'd0,
        SEL_ACK  = 2'd1,
        SEL_EOI  = 2'd2,
        SEL_WHO  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/intr_best_pick.sv
// Combinational best-entry scan over a member set.
// Picks the member with the highest table priority; equal priorities
// resolve to the lowest index because the comparison is strict while
// scanning upward. An empty set reports found=0 and priority -1.
module intr_best_pick #(
    parameter int N  = 16,
    parameter int PW = 5,
    parameter int IW = 4
) (
    input  logic [N-1:0]      member,
    input  logic [N*PW-1:0]   prio_flat,
    output logic              found,
    output logic [IW-1:0]     idx,
    output logic signed [PW:0] prio
);
    // Upward scan keeping the first strictly-better member.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        prio  = '1;
        for (int i = 0; i < N; i++) begin
            if (member[i] && ($signed({1'b0, prio_flat[i*PW +: PW]}) > prio)) begin
                found = 1'b1;
                idx   = IW'(i);
                prio  = $signed({1'b0, prio_flat[i*PW +: PW]});
            end
        end
    end
endmodule

// File: rtl/intr_cpu_deliver.sv
// Per-processor interrupt delivery unit.
// Keeps raised and in-service sets, a task-priority threshold and
// per-source activity flags; drives a level interrupt line.
// Assumes: read and write strobes never coincide; strobes are one-cycle
// pulses; dlv_src < NUM_SRC. Acknowledge/EOI are applied before a
// delivery in the same cycle.
module intr_cpu_deliver #(
    parameter int          NUM_SRC  = 16,
    parameter int          PRIO_W   = 5,
    parameter int          VEC_W    = 8,
    parameter int          TASK_W   = 4,
    parameter int          DATA_W   = 32,
    parameter int          UNIT_ID  = 0,
    parameter logic [7:0]  SPUR_VEC = 8'hFF,
    localparam int         SRC_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       dlv_valid,
    input  logic [SRC_W-1:0]           dlv_src,
    input  logic [PRIO_W-1:0]          dlv_prio,
    input  logic [NUM_SRC*PRIO_W-1:0]  src_prio_flat,
    input  logic [NUM_SRC*VEC_W-1:0]   src_vec_flat,
    input  logic [NUM_SRC-1:0]         src_level,
    input  logic [NUM_SRC-1:0]         src_quiet,
    input  logic                       rd_en,
    input  logic [1:0]                 rd_sel,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_sel,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       irq_out,
    output logic                       ack_clr,
    output logic [SRC_W-1:0]           ack_clr_src,
    output logic [NUM_SRC-1:0]         src_active
);
    import intr_pkg::*;

    localparam int NPICK = 4;   // raised, in-service, raised-after-op, in-service-after-op

    logic [NUM_SRC-1:0] raised_q, svc_q, active_q;
    logic [TASK_W-1:0]  task_q;
    logic               irq_q, clr_q;
    logic [SRC_W-1:0]   clr_src_q;
    logic [DATA_W-1:0]  rd_q;

    logic [NUM_SRC-1:0]       pk_set  [NPICK];
    logic                     pk_any  [NPICK];
    logic [SRC_W-1:0]         pk_idx  [NPICK];
    logic signed [PRIO_W:0]   pk_prio [NPICK];

    logic [NUM_SRC-1:0] raised_a, svc_a, act_a, raised_n, act_n;
    logic [VEC_W-1:0]   ack_vec;
    logic               ack_op, eoi_op, task_wr, ack_edge;
    logic               dlv_ok, dlv_fire, eoi_fire;

    assign ack_op  = rd_en && (rd_sel == SEL_ACK);
    assign eoi_op  = wr_en && (wr_sel == SEL_EOI);
    assign task_wr = wr_en && (wr_sel == SEL_TASK);

    // One best-entry scanner per set of interest.
    for (genvar g = 0; g < NPICK; g++) begin : g_pick
        intr_best_pick #(.N(NUM_SRC), .PW(PRIO_W), .IW(SRC_W)) u_pick (
            .member   (pk_set[g]),
            .prio_flat(src_prio_flat),
            .found    (pk_any[g]),
            .idx      (pk_idx[g]),
            .prio     (pk_prio[g])
        );
    end

    // Route the current and post-operation sets to the scanners.
    always_comb begin
        pk_set[0] = raised_q;
        pk_set[1] = svc_q;
        pk_set[2] = raised_a;
        pk_set[3] = svc_a;
    end

    // Register operation stage: acknowledge or end-of-interrupt.
    always_comb begin
        raised_a = raised_q;
        svc_a    = svc_q;
        act_a    = active_q & ~src_quiet;
        ack_vec  = VEC_W'(SPUR_VEC);
        ack_edge = 1'b0;
        if (ack_op && pk_any[0]) begin
            raised_a[pk_idx[0]] = 1'b0;
            if (act_a[pk_idx[0]] &&
                (src_prio_flat[pk_idx[0]*PRIO_W +: PRIO_W] > PRIO_W'(task_q))) begin
                svc_a[pk_idx[0]] = 1'b1;
                ack_vec = src_vec_flat[pk_idx[0]*VEC_W +: VEC_W];
            end else begin
                act_a[pk_idx[0]] = 1'b0;
            end
            if (!src_level[pk_idx[0]]) begin
                act_a[pk_idx[0]] = 1'b0;
                ack_edge = 1'b1;
            end
        end
        if (eoi_op && pk_any[1]) begin
            svc_a[pk_idx[1]] = 1'b0;
        end
    end

    // Delivery stage, judged against the post-operation sets.
    always_comb begin
        dlv_ok   = dlv_valid && (dlv_prio > PRIO_W'(task_q)) && !raised_a[dlv_src];
        dlv_fire = dlv_ok && ($signed({1'b0, dlv_prio}) >= pk_prio[2]) &&
                   (!pk_any[3] || ($signed({1'b0, dlv_prio}) > pk_prio[3]));
        eoi_fire = eoi_op && pk_any[2] && (!pk_any[3] || (pk_prio[2] > pk_prio[3]));
        raised_n = raised_a;
        act_n    = act_a;
        if (dlv_ok) begin
            raised_n[dlv_src] = 1'b1;
            act_n[dlv_src]    = 1'b1;
        end
    end

    // State registers: sets, flags, threshold and interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raised_q  <= '0;
            svc_q     <= '0;
            active_q  <= '0;
            task_q    <= '1;
            irq_q     <= 1'b0;
            clr_q     <= 1'b0;
            clr_src_q <= '0;
        end else begin
            raised_q  <= raised_n;
            svc_q     <= svc_a;
            active_q  <= act_n;
            irq_q     <= (irq_q && !ack_op) || eoi_fire || dlv_fire;
            clr_q     <= ack_edge;
            clr_src_q <= ack_edge ? pk_idx[0] : clr_src_q;
            if (task_wr) task_q <= wr_data[TASK_W-1:0];
        end
    end

    // Registered read data for the processor port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            case (rd_sel)
                SEL_TASK: rd_q <= DATA_W'(task_q);
                SEL_ACK:  rd_q <= DATA_W'(ack_vec);
                SEL_EOI:  rd_q <= '0;
                default:  rd_q <= DATA_W'(UNIT_ID);
            endcase
        end
    end

    assign rd_data     = rd_q;
    assign irq_out     = irq_q;
    assign ack_clr     = clr_q;
    assign ack_clr_src = clr_src_q;
    assign src_active  = active_q;
endmodule

// File: rtl/intr_cpu_deliver_chk.sv
// Property checker for the delivery unit; attached by bind below.
module intr_cpu_deliver_chk #(
    parameter int NUM_SRC = 16,
    parameter int PRIO_W  = 5,
    parameter int TASK_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               dlv_valid,
    input logic [PRIO_W-1:0]  dlv_prio,
    input logic [NUM_SRC-1:0] src_quiet,
    input logic               rd_en,
    input logic [1:0]         rd_sel,
    input logic               wr_en,
    input logic [1:0]         wr_sel,
    input logic               irq_out,
    input logic               ack_clr,
    input logic [NUM_SRC-1:0] src_active,
    input logic [TASK_W-1:0]  task_q,
    input logic [NUM_SRC-1:0] raised_q
);
    import intr_pkg::*;

    // R3: a delivery at or below the threshold leaves the line unchanged.
    a_r3_low_prio_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && (dlv_prio <= PRIO_W'(task_q)) && !rd_en && !wr_en) |=> $stable(irq_out));

    // R5: the line only rises from a delivery or an end-of-interrupt.
    a_r5_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(dlv_valid || (wr_en && (wr_sel == SEL_EOI))));

    // R6: an acknowledge without a concurrent delivery drops the line.
    a_r6_ack_drops_line: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_sel == SEL_ACK) && !dlv_valid && !wr_en) |=> !irq_out);

    // R9: a pending-clear pulse follows an acknowledge.
    a_r9_clr_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_clr |-> $past(rd_en && (rd_sel == SEL_ACK)));

    // R10: end-of-interrupt with nothing raised cannot assert the line.
    a_r10_eoi_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == SEL_EOI) && (raised_q == '0) && !dlv_valid) |=> !irq_out);

    // R11: quieted sources are inactive next cycle absent a delivery.
    a_r11_quiet_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !dlv_valid |=> ((src_active & $past(src_quiet)) == '0));
endmodule

bind intr_cpu_deliver intr_cpu_deliver_chk #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .TASK_W(TASK_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .dlv_valid(dlv_valid), .dlv_prio(dlv_prio),
    .src_quiet(src_quiet), .rd_en(rd_en), .rd_sel(rd_sel), .wr_en(wr_en),
    .wr_sel(wr_sel), .irq_out(irq_out), .ack_clr(ack_clr),
    .src_active(src_active), .task_q(task_q), .raised_q(raised_q)
);

// File: tb/tb_intr_cpu_deliver.sv
`timescale 1ns/1ps
module tb_intr_cpu_deliver;
    import intr_pkg::*;
    localparam int NS = 16, PW = 5, VW = 8, DW = 32, SW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic dlv_valid = 1'b0;
    logic [SW-1:0] dlv_src = '0;
    logic [PW-1:0] dlv_prio = '0;
    logic [NS*PW-1:0] prio_flat = '0;
    logic [NS*VW-1:0] vec_flat = '0;
    logic [NS-1:0] level = '0, quiet = '0;
    logic rd_en = 1'b0, wr_en = 1'b0;
    logic [1:0] rd_sel = '0, wr_sel = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic irq_out, ack_clr;
    logic [SW-1:0] ack_clr_src;
    logic [NS-1:0] src_active;

    int checks = 0, errors = 0;
    bit done = 1'b0, rd_seen = 1'b0;
    int unsigned exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    intr_cpu_deliver #(.NUM_SRC(NS), .PRIO_W(PW), .VEC_W(VW), .DATA_W(DW), .UNIT_ID(3)) dut (
        .clk(clk), .rst_n(rst_n), .dlv_valid(dlv_valid), .dlv_src(dlv_src),
        .dlv_prio(dlv_prio), .src_prio_flat(prio_flat), .src_vec_flat(vec_flat),
        .src_level(level), .src_quiet(quiet), .rd_en(rd_en), .rd_sel(rd_sel),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_data(rd_data),
        .irq_out(irq_out), .ack_clr(ack_clr), .ack_clr_src(ack_clr_src),
        .src_active(src_active));

    task automatic chk(string tag, int unsigned act, int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare each read result against the scoreboard queue.
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end

    task automatic rd(logic [1:0] sel, int unsigned exp, string tag);
        rd_en = 1'b1; rd_sel = sel; exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic wr(logic [1:0] sel, logic [DW-1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic deliver(int s, int p);
        dlv_valid = 1'b1; dlv_src = SW'(s); dlv_prio = PW'(p);
        @(negedge clk); dlv_valid = 1'b0;
    endtask

    task automatic quiet_pulse(int s);
        quiet[s] = 1'b1; @(negedge clk); quiet[s] = 1'b0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got hung expected finish");
            summary();
        end
    end

    initial begin
        for (int i = 0; i < NS; i++) vec_flat[i*VW +: VW] = VW'(8'h40 + i);
        prio_flat[2*PW +: PW] = 5'd10;
        prio_flat[5*PW +: PW] = 5'd10;
        prio_flat[7*PW +: PW] = 5'd20;
        prio_flat[9*PW +: PW] = 5'd3;
        level[5] = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", irq_out, 0);
        chk("R1 active", src_active, 0);
        rd(SEL_TASK, 32'hF, "R1 task");
        rd(SEL_EOI, 0, "R1 eoi read");
        rd(SEL_WHO, 3, "R1 identity");
        rd(SEL_ACK, 32'hFF, "R6 empty ack");
        chk("R6 irq after empty ack", irq_out, 0);
        // R3 below threshold
        deliver(2, 10);
        chk("R3 irq", irq_out, 0);
        chk("R3 active", src_active[2], 0);
        // R2 threshold keeps 4 bits
        wr(SEL_TASK, 32'h33);
        rd(SEL_TASK, 3, "R2 task");
        // R5 accepted deliveries
        deliver(5, 10);
        chk("R5 irq", irq_out, 1);
        chk("R5 active", src_active[5], 1);
        deliver(2, 10);
        chk("R5 equal prio irq", irq_out, 1);
        // R7 tie goes to lowest index; R9 edge source
        rd(SEL_ACK, 32'h42, "R7 tie ack");
        chk("R6 irq low", irq_out, 0);
        chk("R9 clr pulse", ack_clr, 1);
        chk("R9 clr src", ack_clr_src, 2);
        chk("R9 edge inactive", src_active[2], 0);
        // R4 missed delivery
        deliver(5, 25);
        chk("R4 irq stays", irq_out, 0);
        // R5 preempting delivery
        deliver(7, 20);
        chk("R5 preempt irq", irq_out, 1);
        rd(SEL_ACK, 32'h47, "R7 highest ack");
        chk("R9 clr src 7", ack_clr_src, 7);
        chk("R6 irq low 2", irq_out, 0);
        deliver(9, 3);
        chk("R3 equal to task", irq_out, 0);
        chk("R3 active 9", src_active[9], 0);
        // R10 end of interrupt
        wr(SEL_EOI, 0);
        chk("R10 no reassert", irq_out, 0);
        wr(SEL_EOI, 0);
        chk("R10 reassert", irq_out, 1);
        // R8/R9 level source acknowledge
        rd(SEL_ACK, 32'h45, "R8 level ack");
        chk("R9 level no pulse", ack_clr, 0);
        chk("R9 level active", src_active[5], 1);
        // R8 stale priority gives spurious
        deliver(7, 20);
        chk("R5 over svc", irq_out, 1);
        wr(SEL_TASK, 9);
        prio_flat[7*PW +: PW] = 5'd8;
        rd(SEL_ACK, 32'hFF, "R8 stale prio");
        chk("R8 active cleared", src_active[7], 0);
        wr(SEL_EOI, 0);
        chk("R10 empty eoi", irq_out, 0);
        rd(SEL_ACK, 32'hFF, "R8 raised cleared");
        // R11 quiet input
        quiet_pulse(5);
        chk("R11 quiet", src_active[5], 0);
        deliver(5, 12);
        chk("R5 irq 12", irq_out, 1);
        quiet_pulse(5);
        rd(SEL_ACK, 32'hFF, "R8 inactive spurious");
        chk("R8 irq low", irq_out, 0);
        // R12 acknowledge before same-cycle delivery
        wr(SEL_TASK, 0);
        deliver(2, 10);
        chk("R12 setup irq", irq_out, 1);
        rd_en = 1'b1; rd_sel = SEL_ACK; exp_q.push_back(32'h42); tag_q.push_back("R12 ack");
        dlv_valid = 1'b1; dlv_src = 4'd2; dlv_prio = 5'd10;
        @(negedge clk);
        rd_en = 1'b0; dlv_valid = 1'b0;
        chk("R12 irq", irq_out, 0);
        chk("R12 reraised active", src_active[2], 1);
        wr(SEL_EOI, 0);
        chk("R12 eoi reassert", irq_out, 1);
        rd(SEL_ACK, 32'h42, "R12 second ack");
        @(negedge clk);
        done = 1'b1;
        summary();
    end
endmodule